// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt lines and decides, pin by pin, when each one asks for service. Each line can be set to detect a falling edge, a rising edge, both edges, a low level or a high level. Every line has its own mask bit and its own 4-bit priority field. The block drives one combined request to a parent interrupt controller. Software reaches the block through a small 32-bit register bus. Through it, software sets the detection modes and priorities, reads the pending lines, masks or unmasks lines through separate set and clear addresses, and acknowledges latched edges.

Pins are asynchronous to the block. Each pin passes through a two-stage synchronizer before any detection takes place. In an edge mode, a detected edge sets a sticky flag that stays set until software clears it. In a level mode, the pending state follows the synchronized pin.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0. The mode, priority and pending registers read 0, and every pin is masked. A pending pin with a nonzero priority therefore raises no request until it is unmasked.
- R2: The mode register (address 0) and the priority register (address 1) can be read and written. Pin n's mode field sits at bit 32-(n+1)*SENSE_W, and pin n's 4-bit priority field sits at bit 28-4n. Rewriting one field leaves the other fields unchanged.
- R3: Reads from addresses 3, 4, 5, 6 and 7 return zero.
- R4: Mode code 1 (rising edge) latches a pending flag on a 0-to-1 transition of the pin. The flag stays set after the pin returns low. Pin n's pending flag is bit FLAG_W-1-n of the pending register (address 2).
- R5: Mode code 0 (falling edge) latches a pending flag on a 1-to-0 transition of the pin. A rising transition leaves it clear.
- R6: Mode code 4 (both edges) latches a pending flag on either transition of the pin.
- R7: Mode code 2 (low level) makes the pin pending while the synchronized pin is 0. Mode code 3 (high level) makes it pending while the pin is 1. Nothing is latched in either level mode.
- R8: Writing 1 to bit FLAG_W-1-n of the acknowledge address (5) clears pin n's latched edge flag. Writing 0 to that bit leaves the flag set.
- R9: A mode write that changes pin n's field clears pin n's latched flag. A write that leaves the field at the same value keeps the flag.
- R10: Writing 1 to bit FLAG_W-1-n at address 3 masks pin n, and writing 1 to that bit at address 4 unmasks it. Zero bits at either address change nothing.
- R11: A priority field of 0 blocks its pin from `irq_out` even when the pin is pending and unmasked. Any nonzero value lets the pin through, and the pin's pending bit is unaffected.
- R12: `irq_out` is registered. It is the OR over all pins of pending AND unmasked AND nonzero priority, and it changes one clock after the register or pending state it depends on changes.
- R13: Mode codes 5 to 15 never make a pin pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pins | input | NUM_PINS | External interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The hardest state to reach from the ports is a latched edge flag that must outlive the pin level that caused it. Only a timed pair of pin transitions followed by a read, an acknowledge or a mode rewrite tells a sticky flag apart from a level follower. The bench sweeps every pin through all sixteen mode codes. For each one it drives a low-high-low pulse, with the other pins parked on an inert code. After every step it reads the pending bit and the request line, then acknowledges with a zero bit and with a one bit. Expected values come from arithmetic on which edges have been seen.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int BUS_W = 32;
  localparam int PRIO_W = 4;

  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_PRIO = 3'd1;
  localparam logic [2:0] ADR_PEND = 3'd2;
  localparam logic [2:0] ADR_MSET = 3'd3;
  localparam logic [2:0] ADR_MCLR = 3'd4;
  localparam logic [2:0] ADR_ACK  = 3'd5;

  typedef enum logic [3:0] {
    DET_FALL = 4'd0,
    DET_RISE = 4'd1,
    DET_LOW  = 4'd2,
    DET_HIGH = 4'd3,
    DET_BOTH = 4'd4
  } det_mode_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= async_in[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_s,
  input  logic [SENSE_W-1:0] mode,
  input  logic               ack,
  input  logic               mode_chg,
  output logic               pending,
  output logic               sticky
);
  logic [3:0] code;
  logic       prev_q;
  logic       sticky_q, sticky_d;
  logic       rise, fall, edge_hit, edge_mode, lvl_hit;

  always_comb begin
    code      = 4'(mode);
    rise      = pin_s & ~prev_q;
    fall      = ~pin_s & prev_q;
    edge_hit  = 1'b0;
    lvl_hit   = 1'b0;
    edge_mode = 1'b0;
    case (code)
      DET_FALL: begin edge_hit = fall;        edge_mode = 1'b1; end
      DET_RISE: begin edge_hit = rise;        edge_mode = 1'b1; end
      DET_BOTH: begin edge_hit = rise | fall; edge_mode = 1'b1; end
      DET_LOW:  lvl_hit = ~pin_s;
      DET_HIGH: lvl_hit = pin_s;
      default:  ;
    endcase
    if (mode_chg) sticky_d = 1'b0;
    else          sticky_d = (sticky_q & ~ack) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= pin_s;
      sticky_q <= sticky_d;
    end
  end

  assign pending = edge_mode ? sticky_q : lvl_hit;
  assign sticky  = sticky_q;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N       = 8,
  parameter int SENSE_W = 4,
  parameter int FLAG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic [N-1:0]         pending,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [N*SENSE_W-1:0] mode_flat,
  output logic [N-1:0]         prio_nz,
  output logic [N-1:0]         mask,
  output logic [N-1:0]         ack,
  output logic [N-1:0]         mode_chg
);
  logic [SENSE_W-1:0] mode_q [N];
  logic [SENSE_W-1:0] mode_d [N];
  logic [PRIO_W-1:0]  prio_q [N];
  logic [PRIO_W-1:0]  prio_d [N];
  logic [N-1:0]       mask_q, mask_d;
  logic               we_mode, we_prio, we_mset, we_mclr, we_ack;
  logic [BUS_W-1:0]   rd_mode, rd_prio, rd_pend;

  always_comb begin
    we_mode = bus_sel & bus_wr & (bus_addr == ADR_MODE);
    we_prio = bus_sel & bus_wr & (bus_addr == ADR_PRIO);
    we_mset = bus_sel & bus_wr & (bus_addr == ADR_MSET);
    we_mclr = bus_sel & bus_wr & (bus_addr == ADR_MCLR);
    we_ack  = bus_sel & bus_wr & (bus_addr == ADR_ACK);
    rd_mode = '0;
    rd_prio = '0;
    rd_pend = '0;
    for (int n = 0; n < N; n++) begin
      mode_d[n]   = bus_wdata[BUS_W-(n+1)*SENSE_W +: SENSE_W];
      prio_d[n]   = bus_wdata[BUS_W-(n+1)*PRIO_W +: PRIO_W];
      mode_chg[n] = we_mode && (mode_d[n] != mode_q[n]);
      ack[n]      = we_ack && bus_wdata[FLAG_W-1-n];
      mask_d[n]   = mask_q[n];
      if (we_mset && bus_wdata[FLAG_W-1-n]) mask_d[n] = 1'b1;
      if (we_mclr && bus_wdata[FLAG_W-1-n]) mask_d[n] = 1'b0;
      rd_mode[BUS_W-(n+1)*SENSE_W +: SENSE_W] = mode_q[n];
      rd_prio[BUS_W-(n+1)*PRIO_W +: PRIO_W]   = prio_q[n];
      rd_pend[FLAG_W-1-n] = pending[n];
      mode_flat[n*SENSE_W +: SENSE_W] = mode_q[n];
      prio_nz[n] = |prio_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N; n++) begin
        mode_q[n] <= '0;
        prio_q[n] <= '0;
      end
      mask_q <= '1;
    end else begin
      if (we_mode) begin
        for (int n = 0; n < N; n++) mode_q[n] <= mode_d[n];
      end
      if (we_prio) begin
        for (int n = 0; n < N; n++) prio_q[n] <= prio_d[n];
      end
      if (we_mset | we_mclr) mask_q <= mask_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_MODE: bus_rdata = rd_mode;
      ADR_PRIO: bus_rdata = rd_prio;
      ADR_PEND: bus_rdata = rd_pend;
      default:  bus_rdata = '0;
    endcase
  end

  assign mask = mask_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_out
);
  localparam int MODE_BITS = NUM_PINS * SENSE_W;

  logic [NUM_PINS-1:0]  pin_s;
  logic [NUM_PINS-1:0]  pending, sticky, prio_nz, mask, ack, mode_chg;
  logic [MODE_BITS-1:0] mode_flat;
  logic                 irq_d, irq_q;

  eirq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_pins),
    .sync_out (pin_s)
  );

  eirq_regs #(.N(NUM_PINS), .SENSE_W(SENSE_W), .FLAG_W(FLAG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pending   (pending),
    .bus_rdata (bus_rdata),
    .mode_flat (mode_flat),
    .prio_nz   (prio_nz),
    .mask      (mask),
    .ack       (ack),
    .mode_chg  (mode_chg)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eirq_detect #(.SENSE_W(SENSE_W)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[i]),
      .mode     (mode_flat[i*SENSE_W +: SENSE_W]),
      .ack      (ack[i]),
      .mode_chg (mode_chg[i]),
      .pending  (pending[i]),
      .sticky   (sticky[i])
    );
  end

  always_comb irq_d = |(pending & ~mask & prio_nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int N      = 8,
  parameter int FLAG_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic [N-1:0] pending,
  input logic [N-1:0] sticky,
  input logic [N-1:0] mask,
  input logic [N-1:0] prio_nz,
  input logic         irq_out
);
  logic [N-1:0] wmap;
  logic         wr_mset, wr_mclr, clr_path, req_any;

  always_comb begin
    for (int n = 0; n < N; n++) wmap[n] = bus_wdata[FLAG_W-1-n];
    wr_mset  = bus_sel && bus_wr && (bus_addr == ADR_MSET);
    wr_mclr  = bus_sel && bus_wr && (bus_addr == ADR_MCLR);
    clr_path = bus_sel && bus_wr && (bus_addr == ADR_ACK || bus_addr == ADR_MODE);
    req_any  = |(pending & ~mask & prio_nz);
  end

  // R3
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADR_MSET) |-> (bus_rdata == 32'd0));

  // R10
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(wmap)) == $past(wmap)));

  // R10
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(wmap)) == '0));

  // R8
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky != $past(sticky) && (($past(sticky) & ~sticky) != '0)) |-> $past(clr_path));

  // R12
  irq_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> irq_out);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> !irq_out);
endmodule

bind ext_irq_ctrl eirq_chk #(.N(NUM_PINS), .FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pending   (pending),
  .sticky    (sticky),
  .mask      (mask),
  .prio_nz   (prio_nz),
  .irq_out   (irq_out)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pins;
  logic        sel, wen;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, rv;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(8), .SENSE_W(4), .FLAG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pins(pins), .bus_sel(sel), .bus_wr(wen),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wen = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wen = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wen = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    idle(5);
  endtask

  function automatic logic [31:0] mode_word(input int pin, input int code);
    logic [31:0] w = '0;
    for (int q = 0; q < 8; q++)
      w |= 32'(((q == pin) ? code : 7)) << (28 - 4*q);
    return w;
  endfunction

  // phase 0: low, no edge yet; 1: high after a rise; 2: low after a fall
  function automatic logic exp_pend(input int code, input int phase);
    logic rs = (phase >= 1);
    logic fs = (phase >= 2);
    logic lv = (phase == 1);
    case (code)
      0: return fs;
      1: return rs;
      2: return !lv;
      3: return lv;
      4: return rs | fs;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0: return "R5";
      1: return "R4";
      4: return "R6";
      2, 3: return "R7";
      default: return "R13";
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pins = '0; sel = 1'b0; wen = 1'b0; addr = '0; wdata = '0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    bread(3'd0, rv); check("R1 mode", rv, 32'd0);
    bread(3'd1, rv); check("R1 prio", rv, 32'd0);
    bread(3'd2, rv); check("R1 pend", rv, 32'd0);
    bwrite(3'd1, 32'hFFFF_FFFF);
    bwrite(3'd0, mode_word(0, 3));
    set_pins(8'h01);
    bread(3'd2, rv); check("R1 pend pin0", rv, 32'h80);
    check("R1 masked", {31'd0, irq}, 32'd0);
    bwrite(3'd4, 32'hFF); idle(1);
    check("R10 unmask all", {31'd0, irq}, 32'd1);
    set_pins(8'h00);
    check("R7 level drop", {31'd0, irq}, 32'd0);

    // R2 read-write fields and read-modify-write
    bwrite(3'd0, 32'h0123_4012);
    bread(3'd0, rv); check("R2 mode rb", rv, 32'h0123_4012);
    bwrite(3'd1, 32'h9ABC_DEF1);
    bread(3'd1, rv); check("R2 prio rb", rv, 32'h9ABC_DEF1);
    rv = (rv & ~32'h00F0_0000) | 32'h0050_0000;
    bwrite(3'd1, rv);
    bread(3'd1, rv); check("R2 prio rmw", rv, 32'h9A5C_DEF1);
    bwrite(3'd1, 32'hFFFF_FFFF);

    // R3 write-only and unused addresses read zero
    for (int a = 3; a < 8; a++) begin
      bread(3'(a), rv); check("R3 wo read", rv, 32'd0);
    end

    // sweep every pin through every mode code
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        bwrite(3'd0, mode_word(p, c));
        idle(2);
        for (int ph = 0; ph < 3; ph++) begin
          if (ph == 1) set_pins(8'(1 << p));
          if (ph == 2) set_pins(8'h00);
          bread(3'd2, rv);
          check(tag_of(c), rv, 32'(exp_pend(c, ph)) << (7 - p));
          check({tag_of(c), " irq"}, {31'd0, irq}, {31'd0, exp_pend(c, ph)});
        end
        bwrite(3'd5, 32'hFF & ~(32'd1 << (7 - p))); idle(1);
        bread(3'd2, rv); check("R8 ack zero bit", rv, 32'(exp_pend(c, 2)) << (7 - p));
        bwrite(3'd5, 32'd1 << (7 - p)); idle(1);
        bread(3'd2, rv); check("R8 ack one bit", rv, 32'(c == 2) << (7 - p));
      end
    end

    // R9 mode change clears a latched flag; same value keeps it
    bwrite(3'd0, mode_word(0, 1));
    set_pins(8'h01); set_pins(8'h00);
    bread(3'd2, rv); check("R9 flag set", rv, 32'h80);
    bwrite(3'd0, mode_word(0, 1)); idle(1);
    bread(3'd2, rv); check("R9 same mode keeps", rv, 32'h80);
    bwrite(3'd0, mode_word(0, 4)); idle(1);
    bread(3'd2, rv); check("R9 change clears", rv, 32'h00);

    // R10 / R12 masking and registered output timing, pin3 high level
    bwrite(3'd0, mode_word(3, 3));
    set_pins(8'h08);
    check("R7 high level irq", {31'd0, irq}, 32'd1);
    bwrite(3'd3, 32'h10);
    check("R12 mask lag", {31'd0, irq}, 32'd1);
    idle(1); check("R12 masked next", {31'd0, irq}, 32'd0);
    bwrite(3'd4, 32'hEF); idle(1);
    check("R10 clr zero bit", {31'd0, irq}, 32'd0);
    bwrite(3'd4, 32'h10);
    check("R12 unmask lag", {31'd0, irq}, 32'd0);
    idle(1); check("R12 unmasked next", {31'd0, irq}, 32'd1);
    bwrite(3'd3, 32'hEF); idle(1);
    check("R10 set zero bit", {31'd0, irq}, 32'd1);

    // R11 priority zero blocks, pending still visible
    bwrite(3'd1, 32'hFFF0_FFFF); idle(1);
    check("R11 prio zero", {31'd0, irq}, 32'd0);
    bread(3'd2, rv); check("R11 pend kept", rv, 32'h10);
    bwrite(3'd1, 32'h0001_0000); idle(1);
    check("R11 prio nonzero", {31'd0, irq}, 32'd1);
    set_pins(8'h00);
    check("R12 drop", {31'd0, irq}, 32'd0);

    finish_run();
  end
endmodule